// File: doc/BRIEF.md
# Serial Character Sync Hunter

This block sits on the receive side of a bit-synchronous serial link. Once per bit time it takes one data bit, qualified by a receive clock enable. While it hunts, it compares the most recent bits against a programmed sync pattern. In single-byte mode the pattern is one byte. In two-byte mode it is a pair of bytes that must arrive in a fixed order. When the pattern is found, the block leaves the hunt state and starts framing the following bits into bytes, which it queues in a small receive FIFO.

The hunt state is entered only by an explicit command strobe, and it ends only on a pattern match. A status flag shows the hunt state, and each change of that flag raises an interrupt-pending bit that software acknowledges. An active-low detect output pulses for one bit time on every match while it is enabled. This happens in any state and at any bit offset, so external logic should use only the pulse that arrives during hunt. In two-byte mode the framed data passes through a three-bit delay stage before character assembly.

Top module: `char_sync_hunter`

## Requirements
- R1: After reset, `hunting`=1, `irq`=0, `rx_valid`=0, `overrun`=0 and `sync_n`=1.
- R2: A one-cycle `hunt_cmd` sets `hunting` in the next cycle. While `hunt_cmd` is 0, a synchronized block stays synchronized.
- R3: Bits arrive LSB first. The most recent bit is the MSB of the compare window. In single-byte mode (`bisync_mode`=0), a match occurs on a `bit_en` cycle when the newest 8 bits equal `sync_b`, provided at least 8 bits have been received since reset. A match while hunting clears `hunting` in the next cycle. Before the 8th bit no match is possible.
- R4: In two-byte mode (`bisync_mode`=1), a match needs at least 16 received bits, with the older 8 equal to `sync_a` and the newer 8 equal to `sync_b`.
- R5: `irq` is set in the cycle after any change of `hunting`, including a change caused by `hunt_cmd`. It is cleared by `irq_ack`, and a new change wins over an acknowledge.
- R6: With `sync_out_en`=1, `sync_n` goes low after every matching `bit_en` cycle, in any state and at any bit offset. It stays low until the next `bit_en` cycle.
- R7: With `sync_out_en`=0, `sync_n` stays 1.
- R8: In single-byte mode, the first byte is built from the 8 bits that follow the pattern. The first of these bits goes to `rx_data[0]`. The byte becomes visible after the 8th of those bits.
- R9: In two-byte mode, the bytes are identical, but each becomes visible 3 bit times later (after the 11th bit following the pattern).
- R10: The FIFO holds 3 bytes and delivers them in order. A byte is popped when `rx_valid` and `rx_ready` are both 1. `rx_data` holds steady while it is not popped.
- R11: A byte completed while the FIFO is full is discarded and sets `overrun`, which stays set until reset.
- R12: `hunt_cmd` during a partial byte discards that byte. No byte is queued until a new match, and framing restarts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Receive bit strobe, one cycle per bit |
| bit_in | input | 1 | Serial data bit |
| hunt_cmd | input | 1 | Enter-hunt command strobe |
| bisync_mode | input | 1 | 0 single-byte pattern, 1 two-byte pattern |
| sync_a | input | 8 | Older pattern byte (two-byte mode) |
| sync_b | input | 8 | Pattern byte; newer byte in two-byte mode |
| sync_out_en | input | 1 | Enables the detect pulse |
| irq_ack | input | 1 | Clears the interrupt-pending bit |
| rx_ready | input | 1 | Consumer accepts the head byte |
| sync_n | output | 1 | Active-low match pulse, one bit time |
| hunting | output | 1 | Hunt status flag |
| irq | output | 1 | Hunt-status change pending |
| rx_data | output | 8 | Head byte of the FIFO |
| rx_valid | output | 1 | FIFO not empty |
| overrun | output | 1 | Sticky FIFO overflow |

## Verification
A wrong compare window or fill count shows up within one bit time of the pattern's last bit. `hunting` then clears too early or too late, and `sync_n` misses its pulse. A framing counter that starts at the wrong bit corrupts the first byte that appears on `rx_data`. A missing or extra delay stage moves `rx_valid` by three bit times in two-byte mode. Faults in the FIFO pointers or occupancy show on the third or fourth queued byte, through the byte order or through `overrun`.

// File: rtl/char_sync_hunter.sv
module char_sync_hunter #(
  parameter int DEPTH = 3,
  parameter int DLY   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       hunt_cmd,
  input  logic       bisync_mode,
  input  logic [7:0] sync_a,
  input  logic [7:0] sync_b,
  input  logic       sync_out_en,
  input  logic       irq_ack,
  input  logic       rx_ready,
  output logic       sync_n,
  output logic       hunting,
  output logic       irq,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [3:0] SKIP = 4'(16 - DLY);

  logic [15:0]    win;
  logic [4:0]     fill;
  logic           pulse;
  logic [DLY-1:0] dly;
  logic [7:0]     sh;
  logic [3:0]     bcnt;
  logic [7:0]     mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  wire [15:0] win_n   = {bit_in, win[15:1]};
  wire        enough  = bisync_mode ? (fill >= 5'd15) : (fill >= 5'd7);
  wire        pat     = bisync_mode ? (win_n == {sync_b, sync_a}) : (win_n[15:8] == sync_b);
  wire        match   = bit_en && enough && pat;
  wire        hunt_nx = hunt_cmd ? 1'b1 : (match ? 1'b0 : hunting);
  wire        a_bit   = bisync_mode ? dly[0] : bit_in;
  wire        take    = bit_en && !hunting;
  wire        push    = take && (bcnt == 4'd7);
  wire [7:0]  byte_n  = {a_bit, sh[7:1]};
  wire        full    = (cnt == CW'(DEPTH));
  wire        pop     = rx_valid && rx_ready;
  wire        wr      = push && !full;

  assign sync_n   = ~(pulse & sync_out_en);
  assign rx_valid = (cnt != '0);
  assign rx_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
      fill <= '0;
      pulse <= 1'b0;
      dly <= '0;
      hunting <= 1'b1;
      irq <= 1'b0;
    end else begin
      if (bit_en) begin
        win <= win_n;
        if (fill != 5'd16) fill <= fill + 5'd1;
        pulse <= match;
        dly <= {bit_in, dly[DLY-1:1]};
      end
      hunting <= hunt_nx;
      irq <= (hunt_nx != hunting) | (irq & ~irq_ack);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      bcnt <= '0;
    end else if (match && hunting) begin
      bcnt <= bisync_mode ? SKIP : 4'd0;
    end else if (take) begin
      sh <= byte_n;
      bcnt <= (bcnt == 4'd7) ? 4'd0 : bcnt + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr) begin
        mem[wp] <= byte_n;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (push && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/char_sync_hunter_chk.sv
module char_sync_hunter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       hunt_cmd,
  input logic       sync_out_en,
  input logic       rx_ready,
  input logic       sync_n,
  input logic       hunting,
  input logic       irq,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       overrun
);
  AST_HUNT_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n) hunt_cmd |=> hunting); // R2
  AST_HUNT_EXIT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(hunting) |-> $past(bit_en)); // R3
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) (hunting != $past(hunting)) |-> irq); // R5
  AST_PULSE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_n) && $past(sync_out_en) && sync_out_en) |-> $past(bit_en)); // R6
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> rx_valid); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> $stable(rx_data)); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R11
endmodule

bind char_sync_hunter char_sync_hunter_chk u_chk (.*);

// File: tb/sim_char_sync_hunter.sv
module sim_char_sync_hunter;
  localparam int TCLK = 10;
  logic clk = 0, rst_n = 0, bit_en = 0, bit_in = 0, hunt_cmd = 0, bisync_mode = 0;
  logic [7:0] sync_a = 0, sync_b = 0;
  logic sync_out_en = 1, irq_ack = 0, rx_ready = 0;
  logic sync_n, hunting, irq, rx_valid, overrun;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  char_sync_hunter u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1;
    @(negedge clk); bit_en = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic strobe_hunt();
    @(negedge clk); hunt_cmd = 1;
    @(negedge clk); hunt_cmd = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    chk(rx_valid && rx_data == exp, req, {rx_valid, rx_data}, {1'b1, exp});
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  initial begin
    #(TCLK * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk(hunting && !irq && !rx_valid && !overrun && sync_n, "R1",
        {hunting, irq, rx_valid, overrun, sync_n}, 5'b10001);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v) ^ 8'hA5;
      bisync_mode = 0; sync_b = 8'(v);
      do_reset();
      for (int i = 0; i < 7; i++) send_bit(v[i]);
      chk(hunting, "R3 early", hunting, 1);
      send_bit(v[7]);
      chk(!hunting, "R3 match", hunting, 0);
      chk(irq, "R5 set", irq, 1);
      ack();
      chk(!irq, "R5 ack", irq, 0);
      for (int i = 0; i < 7; i++) send_bit(d[i]);
      chk(!rx_valid, "R8 early", rx_valid, 0);
      send_bit(d[7]);
      chk(rx_valid && rx_data == d, "R8 byte", rx_data, d);
      chk(!hunting, "R2 stays", hunting, 0);
    end

    for (int v = 0; v < 256; v += 5) begin
      logic [7:0] a, b, d;
      a = 8'(v); b = ~{a[3:0], a[7:4]}; d = a + 8'd3;
      bisync_mode = 1; sync_a = a; sync_b = b;
      do_reset();
      send_byte(a);
      for (int i = 0; i < 7; i++) send_bit(b[i]);
      chk(hunting, "R4 early", hunting, 1);
      send_bit(b[7]);
      chk(!hunting, "R4 match", hunting, 0);
      send_byte(d);
      chk(!rx_valid, "R9 delayed", rx_valid, 0);
      send_bit(0); send_bit(0); send_bit(0);
      chk(rx_valid && rx_data == d, "R9 byte", rx_data, d);
    end

    bisync_mode = 0; sync_b = 8'h55; sync_out_en = 1;
    do_reset();
    send_byte(8'h55);
    chk(!sync_n, "R6 hunt pulse", sync_n, 0);
    @(negedge clk);
    chk(!sync_n, "R6 held", sync_n, 0);
    send_bit(1);
    chk(sync_n, "R6 end", sync_n, 1);
    send_bit(0);
    chk(!sync_n, "R6 off boundary", sync_n, 0);
    chk(!hunting && !irq == 0, "R2 synced", hunting, 0);
    ack();
    chk(!irq, "R5 no change", irq, 0);
    sync_out_en = 0;
    send_bit(1); send_bit(0);
    chk(sync_n, "R7 masked", sync_n, 1);
    sync_out_en = 1;

    sync_b = 8'hF0;
    do_reset();
    send_byte(8'hF0);
    chk(!hunting, "R3 F0", hunting, 0);
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    strobe_hunt();
    chk(hunting && irq, "R12 rehunt", {hunting, irq}, 2'b11);
    send_bit(1); send_bit(1); send_bit(1); send_bit(1);
    chk(!rx_valid, "R12 dropped", rx_valid, 0);
    send_byte(8'hF0);
    chk(!hunting, "R12 resync", hunting, 0);
    send_byte(8'h3C);
    pop_chk(8'h3C, "R12 framing");

    do_reset();
    send_byte(8'hF0);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    chk(!overrun, "R10 three fit", overrun, 0);
    send_byte(8'h44);
    chk(overrun, "R11 overrun", overrun, 1);
    pop_chk(8'h11, "R10 order");
    pop_chk(8'h22, "R10 order");
    pop_chk(8'h33, "R11 discard");
    chk(!rx_valid && overrun, "R11 sticky", {rx_valid, overrun}, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule